// File: doc/BRIEF.md
# Split Transaction Descriptor Status Updater

This block holds one bulk split-transaction descriptor in a register and rewrites its status fields after every bus transaction result. Software writes the descriptor through a load strobe: the valid flag, the initial data toggle, the programmed error-retry start value, the NAK reload value, the branch selection, a stored branch pointer and the descriptor's own index. The bus engine then reports each transaction outcome as a 3-bit result code. The block updates the active, valid, halt, babble, transaction-error, split-phase, toggle and two retry-counter fields within one clock.

The descriptor can retire in four ways. A completed complete-split retires it normally and keeps valid set. Running out of error retries or NAK retries retires it and clears valid. Babble also clears valid. A start split that is acknowledged moves the descriptor to the complete-split phase. A NYET in the complete-split phase keeps the phase, so the complete split is issued again. The block also gives the index of the descriptor to process after this one. That index is either the sequential successor or the stored branch pointer.

Top module: `split_desc_updater`

## Requirements
- R1: After reset every status output is 0, the counters are 0, and `next_idx_o` is 1.
- R2: While `ld_i` is high, the next cycle shows the loaded fields. Active equals the loaded valid. Halt, babble and transaction error are 0. The phase is 0. The error counter equals the loaded start value and the NAK counter equals the loaded reload value. A load takes priority over a result in the same cycle.
- R3: Result codes are ACK=0, NAK=1, NYET=2, no response=3, bad response=4, babble=5, data=6, and 7 is reserved. A result has an effect only when `res_vld_i` is high, active is 1 and no load is present. In every other case, and for code 7, no output changes.
- R4: No response or bad response with an error counter above 1 decrements the counter by one. No other output changes.
- R5: No response or bad response with an error counter of 1 or 0 sets the counter to 0, sets halt and transaction error, and clears valid and active, all in the same cycle.
- R6: NAK or NYET sets the error counter back to the programmed start value.
- R7: With a non-zero reload value, NAK decrements the NAK counter. A NAK that takes the counter from 1 to 0 clears valid and active and leaves halt and transaction error unchanged.
- R8: With a reload value of 0, NAK leaves the NAK counter unchanged and never retires the descriptor.
- R9: Babble sets the babble flag and clears active and valid.
- R10: ACK in the start-split phase (phase 0) sets the phase to 1 and keeps active. Data in the start-split phase has no effect.
- R11: ACK or data in the complete-split phase inverts the toggle, returns the phase to 0 and clears active. Valid stays set.
- R12: NYET leaves the phase, the toggle and the NAK counter unchanged.
- R13: `next_idx_o` is the stored branch pointer when branch is selected. Otherwise it is the descriptor index plus one, modulo 32.
- R14: Active is never 1 while valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_i | input | 1 | Software load strobe |
| ld_valid_i | input | 1 | Valid flag to load (active follows it) |
| ld_toggle_i | input | 1 | Initial data toggle |
| ld_cerr_i | input | 2 | Error-retry start value |
| ld_reload_i | input | 4 | NAK reload value |
| ld_branch_i | input | 1 | 1 selects the branch pointer as the next index |
| ld_ptr_i | input | 5 | Stored branch pointer |
| ld_idx_i | input | 5 | Index of this descriptor |
| res_vld_i | input | 1 | Result strobe |
| res_code_i | input | 3 | Result code (see R3) |
| active_o | output | 1 | Descriptor active |
| valid_o | output | 1 | Descriptor valid |
| halt_o | output | 1 | Halted by error exhaustion |
| babble_o | output | 1 | Babble seen |
| xerr_o | output | 1 | Transaction error |
| phase_o | output | 1 | 0 start split, 1 complete split |
| toggle_o | output | 1 | Data toggle |
| cerr_o | output | 2 | Error-retry counter |
| nakcnt_o | output | 4 | NAK counter |
| next_idx_o | output | 5 | Index of the next descriptor to process |

## Verification
Assertions check the following on every cycle. Active never appears without valid. Babble retires the descriptor on the next cycle. A rising halt comes together with transaction error and cleared flags. NAK or NYET restores the error counter. An acknowledged start split moves to the complete phase. A zero reload keeps the NAK counter still. A result arriving while inactive changes nothing. The bench scenarios show the rest: decrement sequences that end in retirement on the right attempt, the load-over-result priority, toggle inversion across a full split, the reserved code, and index wrap-around and branching.

// File: rtl/split_desc_pkg.sv
package split_desc_pkg;

    parameter int CERR_W = 2;
    parameter int NAK_W  = 4;
    parameter int IDX_W  = 5;

    typedef enum logic [2:0] {
        RES_ACK     = 3'd0,
        RES_NAK     = 3'd1,
        RES_NYET    = 3'd2,
        RES_NORESP  = 3'd3,
        RES_BADRESP = 3'd4,
        RES_BABBLE  = 3'd5,
        RES_DATA    = 3'd6,
        RES_RSVD    = 3'd7
    } res_code_e;

    typedef struct packed {
        logic              active;
        logic              valid;
        logic              halt;
        logic              babble;
        logic              xerr;
        logic              phase;
        logic              toggle;
        logic [CERR_W-1:0] cerr;
        logic [CERR_W-1:0] cerr_init;
        logic [NAK_W-1:0]  nakcnt;
        logic [NAK_W-1:0]  reload;
        logic              branch;
        logic [IDX_W-1:0]  ptr;
        logic [IDX_W-1:0]  idx;
    } desc_state_t;

endpackage

// File: rtl/err_retry_unit.sv
module err_retry_unit #(
    parameter int W = 2
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] init_i,
    input  logic         err_i,
    input  logic         restore_i,
    output logic [W-1:0] cnt_o,
    output logic         exhausted_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic last_try;
    assign last_try = (cnt_i <= ONE);

    always_comb begin
        cnt_o       = cnt_i;
        exhausted_o = 1'b0;
        if (restore_i) begin
            cnt_o = init_i;
        end else if (err_i) begin
            if (last_try) begin
                cnt_o       = '0;
                exhausted_o = 1'b1;
            end else begin
                cnt_o = cnt_i - ONE;
            end
        end
    end
endmodule

// File: rtl/nak_retry_unit.sv
module nak_retry_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] reload_i,
    input  logic         nak_i,
    output logic [W-1:0] cnt_o,
    output logic         expired_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic counting;
    assign counting = (reload_i != '0);

    always_comb begin
        cnt_o     = cnt_i;
        expired_o = 1'b0;
        if (nak_i && counting) begin
            if (cnt_i <= ONE) begin
                cnt_o     = '0;
                expired_o = 1'b1;
            end else begin
                cnt_o = cnt_i - ONE;
            end
        end
    end
endmodule

// File: rtl/next_idx_sel.sv
module next_idx_sel #(
    parameter int W = 5
) (
    input  logic [W-1:0] idx_i,
    input  logic [W-1:0] ptr_i,
    input  logic         branch_i,
    output logic [W-1:0] next_o
);
    logic [W-1:0] seq;
    assign seq    = idx_i + W'(1);
    assign next_o = branch_i ? ptr_i : seq;
endmodule

// File: rtl/split_desc_updater.sv
module split_desc_updater
    import split_desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              ld_valid_i,
    input  logic              ld_toggle_i,
    input  logic [CERR_W-1:0] ld_cerr_i,
    input  logic [NAK_W-1:0]  ld_reload_i,
    input  logic              ld_branch_i,
    input  logic [IDX_W-1:0]  ld_ptr_i,
    input  logic [IDX_W-1:0]  ld_idx_i,
    input  logic              res_vld_i,
    input  logic [2:0]        res_code_i,
    output logic              active_o,
    output logic              valid_o,
    output logic              halt_o,
    output logic              babble_o,
    output logic              xerr_o,
    output logic              phase_o,
    output logic              toggle_o,
    output logic [CERR_W-1:0] cerr_o,
    output logic [NAK_W-1:0]  nakcnt_o,
    output logic [IDX_W-1:0]  next_idx_o
);
    desc_state_t st_q, st_d;
    res_code_e   code;
    logic        accept;
    logic        is_err, is_restore, is_nak;
    logic [CERR_W-1:0] cerr_nx;
    logic              cerr_exh;
    logic [NAK_W-1:0]  nak_nx;
    logic              nak_exp;

    assign code       = res_code_e'(res_code_i);
    assign accept     = res_vld_i && st_q.active && !ld_i;
    assign is_err     = accept && (code == RES_NORESP || code == RES_BADRESP);
    assign is_restore = accept && (code == RES_NAK || code == RES_NYET);
    assign is_nak     = accept && (code == RES_NAK);

    err_retry_unit #(.W(CERR_W)) u_err (
        .cnt_i       (st_q.cerr),
        .init_i      (st_q.cerr_init),
        .err_i       (is_err),
        .restore_i   (is_restore),
        .cnt_o       (cerr_nx),
        .exhausted_o (cerr_exh)
    );

    nak_retry_unit #(.W(NAK_W)) u_nak (
        .cnt_i     (st_q.nakcnt),
        .reload_i  (st_q.reload),
        .nak_i     (is_nak),
        .cnt_o     (nak_nx),
        .expired_o (nak_exp)
    );

    next_idx_sel #(.W(IDX_W)) u_idx (
        .idx_i    (st_q.idx),
        .ptr_i    (st_q.ptr),
        .branch_i (st_q.branch),
        .next_o   (next_idx_o)
    );

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.valid     = ld_valid_i;
            st_d.active    = ld_valid_i;
            st_d.halt      = 1'b0;
            st_d.babble    = 1'b0;
            st_d.xerr      = 1'b0;
            st_d.phase     = 1'b0;
            st_d.toggle    = ld_toggle_i;
            st_d.cerr      = ld_cerr_i;
            st_d.cerr_init = ld_cerr_i;
            st_d.nakcnt    = ld_reload_i;
            st_d.reload    = ld_reload_i;
            st_d.branch    = ld_branch_i;
            st_d.ptr       = ld_ptr_i;
            st_d.idx       = ld_idx_i;
        end else if (accept) begin
            st_d.cerr   = cerr_nx;
            st_d.nakcnt = nak_nx;
            unique case (code)
                RES_BABBLE: begin
                    st_d.babble = 1'b1;
                    st_d.active = 1'b0;
                    st_d.valid  = 1'b0;
                end
                RES_NORESP, RES_BADRESP: begin
                    if (cerr_exh) begin
                        st_d.xerr   = 1'b1;
                        st_d.halt   = 1'b1;
                        st_d.valid  = 1'b0;
                        st_d.active = 1'b0;
                    end
                end
                RES_NAK: begin
                    if (nak_exp) begin
                        st_d.valid  = 1'b0;
                        st_d.active = 1'b0;
                    end
                end
                RES_ACK, RES_DATA: begin
                    if (st_q.phase) begin
                        st_d.toggle = ~st_q.toggle;
                        st_d.phase  = 1'b0;
                        st_d.active = 1'b0;
                    end else if (code == RES_ACK) begin
                        st_d.phase = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign valid_o  = st_q.valid;
    assign halt_o   = st_q.halt;
    assign babble_o = st_q.babble;
    assign xerr_o   = st_q.xerr;
    assign phase_o  = st_q.phase;
    assign toggle_o = st_q.toggle;
    assign cerr_o   = st_q.cerr;
    assign nakcnt_o = st_q.nakcnt;

    // R14
    active_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> valid_o);

    // R9
    babble_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && code == RES_BABBLE) |=> (babble_o && !active_o && !valid_o));

    // R5
    halt_with_xerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> (xerr_o && !valid_o && !active_o));

    // R6
    cerr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (code == RES_NAK || code == RES_NYET)) |=> (cerr_o == $past(st_q.cerr_init)));

    // R10
    start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && code == RES_ACK && !phase_o) |=> (phase_o && active_o));

    // R8
    nak_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && code == RES_NAK && st_q.reload == '0) |=> ($stable(nakcnt_o) && valid_o));

    // R3
    inactive_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_i && !active_o && !ld_i) |=> $stable(st_q));
endmodule

// File: tb/split_desc_updater_tb.sv
`timescale 1ns/1ps
module split_desc_updater_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_i = 1'b0, ld_valid_i = 1'b0, ld_toggle_i = 1'b0, ld_branch_i = 1'b0;
    logic [1:0] ld_cerr_i = '0;
    logic [3:0] ld_reload_i = '0;
    logic [4:0] ld_ptr_i = '0, ld_idx_i = '0;
    logic       res_vld_i = 1'b0;
    logic [2:0] res_code_i = '0;
    logic       active_o, valid_o, halt_o, babble_o, xerr_o, phase_o, toggle_o;
    logic [1:0] cerr_o;
    logic [3:0] nakcnt_o;
    logic [4:0] next_idx_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_act, m_val, m_halt, m_bab, m_xerr, m_ph, m_tog;
    int m_cerr, m_cinit, m_nak, m_rl, m_br, m_ptr, m_idx;

    always #2.5 clk = ~clk;

    split_desc_updater u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_i(ld_i), .ld_valid_i(ld_valid_i), .ld_toggle_i(ld_toggle_i),
        .ld_cerr_i(ld_cerr_i), .ld_reload_i(ld_reload_i), .ld_branch_i(ld_branch_i),
        .ld_ptr_i(ld_ptr_i), .ld_idx_i(ld_idx_i),
        .res_vld_i(res_vld_i), .res_code_i(res_code_i),
        .active_o(active_o), .valid_o(valid_o), .halt_o(halt_o), .babble_o(babble_o),
        .xerr_o(xerr_o), .phase_o(phase_o), .toggle_o(toggle_o),
        .cerr_o(cerr_o), .nakcnt_o(nakcnt_o), .next_idx_o(next_idx_o)
    );

    task automatic cmp1(string tag, string fld, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d", tag, fld, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        cmp1(tag, "active", int'(active_o), m_act);
        cmp1(tag, "valid", int'(valid_o), m_val);
        cmp1(tag, "halt", int'(halt_o), m_halt);
        cmp1(tag, "babble", int'(babble_o), m_bab);
        cmp1(tag, "xerr", int'(xerr_o), m_xerr);
        cmp1(tag, "phase", int'(phase_o), m_ph);
        cmp1(tag, "toggle", int'(toggle_o), m_tog);
        cmp1(tag, "cerr", int'(cerr_o), m_cerr);
        cmp1(tag, "nakcnt", int'(nakcnt_o), m_nak);
        cmp1(tag, "next_idx", int'(next_idx_o), m_br != 0 ? m_ptr : (m_idx + 1) % 32);
    endtask

    task automatic finish_split();
        m_tog = 1 - m_tog;
        m_ph  = 0;
        m_act = 0;
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic cycle(bit ld, int lv, int lt, int lc, int lr, int lb, int lp, int li,
                         bit rv, int rc, string tag);
        ld_i = ld; ld_valid_i = lv[0]; ld_toggle_i = lt[0]; ld_cerr_i = lc[1:0];
        ld_reload_i = lr[3:0]; ld_branch_i = lb[0]; ld_ptr_i = lp[4:0]; ld_idx_i = li[4:0];
        res_vld_i = rv; res_code_i = rc[2:0];
        if (ld) begin
            m_val = lv; m_act = lv; m_halt = 0; m_bab = 0; m_xerr = 0; m_ph = 0;
            m_tog = lt; m_cerr = lc; m_cinit = lc; m_rl = lr; m_nak = lr;
            m_br = lb; m_ptr = lp; m_idx = li;
        end else if (rv && m_act != 0) begin
            case (rc)
                0: if (m_ph == 0) m_ph = 1; else finish_split();
                1: begin
                    m_cerr = m_cinit;
                    if (m_rl != 0) begin
                        if (m_nak > 1) m_nak--;
                        else begin m_nak = 0; m_val = 0; m_act = 0; end
                    end
                end
                2: m_cerr = m_cinit;
                3, 4: begin
                    if (m_cerr > 1) m_cerr--;
                    else begin m_cerr = 0; m_xerr = 1; m_halt = 1; m_val = 0; m_act = 0; end
                end
                5: begin m_bab = 1; m_val = 0; m_act = 0; end
                6: if (m_ph == 1) finish_split();
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        ld_i = 1'b0; res_vld_i = 1'b0;
        compare_all(tag);
    endtask

    task automatic load(int v, int t, int c, int r, int b, int p, int i, string tag);
        cycle(1'b1, v, t, c, r, b, p, i, 1'b0, 0, tag);
    endtask

    task automatic res(int code, string tag);
        cycle(1'b0, 0, 0, 0, 0, 0, 0, 0, 1'b1, code, tag);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_act = 0; m_val = 0; m_halt = 0; m_bab = 0; m_xerr = 0; m_ph = 0; m_tog = 0;
        m_cerr = 0; m_cinit = 0; m_nak = 0; m_rl = 0; m_br = 0; m_ptr = 0; m_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2 load, R13 sequential index
        load(1, 0, 3, 4, 0, 9, 7, "R2");
        // R10 data in start phase ignored, then ACK enters complete phase
        res(6, "R10");
        res(0, "R10");
        // R12 NYET keeps complete phase
        res(2, "R12");
        // R11 complete split ACK finishes
        res(0, "R11");
        // R3 inactive descriptor ignores results
        res(1, "R3");
        res(3, "R3");

        // R11 complete split via data
        load(1, 1, 2, 4, 0, 0, 3, "R2");
        res(0, "R10");
        res(6, "R11");

        // R4 / R6 / R5 error path
        load(1, 0, 3, 3, 0, 0, 0, "R2");
        res(7, "R3");
        res(3, "R4");
        res(1, "R6");
        res(2, "R6");
        res(4, "R4");
        res(4, "R4");
        res(3, "R5");
        res(0, "R3");

        // R5 with a start value of 1 retires on the first error
        load(1, 0, 1, 5, 0, 0, 4, "R2");
        res(4, "R5");

        // R7 NAK counter retires
        load(1, 0, 2, 2, 0, 0, 5, "R2");
        res(1, "R7");
        res(1, "R7");
        res(1, "R3");

        // R8 zero reload never retires
        load(1, 1, 2, 0, 0, 0, 6, "R2");
        for (int k = 0; k < 20; k++) res(1, "R8");
        res(2, "R12");

        // R9 babble
        load(1, 0, 3, 4, 0, 0, 8, "R2");
        res(0, "R10");
        res(5, "R9");

        // R13 branch selection and wrap-around
        load(1, 0, 3, 4, 1, 19, 2, "R13");
        load(1, 0, 3, 4, 0, 19, 31, "R13");

        // R14 load with valid 0 keeps active 0, results ignored
        load(0, 0, 3, 4, 0, 0, 1, "R14");
        res(0, "R14");

        // R2 load wins over a simultaneous result
        load(1, 0, 3, 4, 0, 0, 1, "R2");
        cycle(1'b1, 1, 1, 2, 7, 0, 0, 12, 1'b1, 5, "R2");

        // idle cycles
        for (int k = 0; k < 3; k++) cycle(1'b0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 0, "R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule